// File: doc/BRIEF.md
# Programmable Rate Divider

The block divides an input clock by a run-time ratio N. It emits a pulse one input clock period wide once every N input cycles. N is an 8-bit unsigned value, with bit 0 as the least significant bit. The count is held in a chain of 4-bit down-counting stages. Each stage passes an active-low borrow to the next stage, so the upper stage steps only when every lower stage sits at zero. When the whole chain reaches zero, that terminal state reloads the chain on the same clock edge and raises the output pulse. No input cycle is lost between periods.

The ratio input is sampled only at a reload edge. Software or a neighbouring block may therefore change it at any time, and the output period changes cleanly at the next boundary. A ratio of zero is not a legal value and must not be applied. Stage width and stage count are parameters. The defaults give an 8-bit ratio, so N can range from 1 to 255.

Top module: `rate_divider`

## Requirements
- R1: While rst_ni is low, pulse_o is low.
- R2: The first rising clock edge after reset release loads ratio N. pulse_o first goes high at the N-th rising edge after that load edge and stays low before it.
- R3: For a steady ratio N of 2 or more, pulse_o is high for exactly one input cycle, and successive rising edges of pulse_o are exactly N input cycles apart.
- R4: With N equal to 1, pulse_o stays high continuously once the first pulse has appeared.
- R5: The all-ones ratio (255, every bit of ratio_i set) gives a period of exactly 255 input cycles.
- R6: A change of ratio_i in the middle of a period has no effect on that period. The new value sets the length of the period that starts at the next pulse.
- R7: Ratios that end the low stage's range or cross into the upper stage (15, 16, 17) give periods of exactly N cycles.
- R8: When the chain is neither loading nor idle, it decrements by exactly one per cycle, including borrows across stage boundaries. On a reload edge it takes the value ratio_i minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 8 | Divide ratio N, unsigned binary, bit 0 is the LSB, must be nonzero |
| pulse_o | output | 1 | Divided output, high for one input cycle per period |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a running period. Such a change must leave the current period alone and take effect only at the next reload. The bench reaches it by starting a long period of 40 cycles and switching the ratio to 7 ten cycles after a pulse. It then measures that the current gap is still 40 and the following gap is 7. The stage-boundary ratios and the all-ones ratio are each measured over two consecutive periods, after a resynchronising pulse, so that the borrow path between the two stages is exercised at every reload.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned STAGE_W_DEF  = 4;
  localparam int unsigned N_STAGES_DEF = 2;

  typedef enum logic {
    CT_IDLE = 1'b0,
    CT_RUN  = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  input  logic         cin_ni,
  output logic [W-1:0] q_o,
  output logic         cout_no
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= preset_i;
    else if (!cin_ni) q_q <= q_q - W'(1);
  end

  // borrow to next stage: only when enabled and this stage is at zero
  assign cout_no = cin_ni | (q_q != '0);
  assign q_o     = q_q;
endmodule

// File: rtl/div_chain.sv
module div_chain #(
  parameter int unsigned STAGE_W  = 4,
  parameter int unsigned N_STAGES = 2,
  localparam int unsigned TOT_W   = STAGE_W * N_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TOT_W-1:0] preset_i,
  input  logic             en_i,
  output logic [TOT_W-1:0] cnt_o,
  output logic             term_o
);
  logic [N_STAGES:0] borrow_n;

  assign borrow_n[0] = ~en_i;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    div_stage #(.W(STAGE_W)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .preset_i (preset_i[s*STAGE_W +: STAGE_W]),
      .cin_ni   (borrow_n[s]),
      .q_o      (cnt_o[s*STAGE_W +: STAGE_W]),
      .cout_no  (borrow_n[s+1])
    );
  end

  assign term_o = ~borrow_n[N_STAGES];
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  input  logic         term_i,
  output logic         load_o,
  output logic         en_o,
  output logic [W-1:0] preset_o,
  output logic         pulse_o
);
  ctrl_state_e state_q;
  logic        pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CT_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= CT_RUN;
      pulse_q <= (state_q == CT_RUN) & term_i;
    end
  end

  assign en_o     = (state_q == CT_RUN);
  assign load_o   = (state_q == CT_IDLE) | term_i;
  // N states per period: N-1 down to 0
  assign preset_o = ratio_i - W'(1);
  assign pulse_o  = pulse_q;
endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int unsigned STAGE_W  = div_pkg::STAGE_W_DEF,
  parameter int unsigned N_STAGES = div_pkg::N_STAGES_DEF,
  localparam int unsigned RATIO_W = STAGE_W * N_STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               pulse_o
);
  logic               load;
  logic               en;
  logic               term;
  logic [RATIO_W-1:0] preset;
  logic [RATIO_W-1:0] cnt;

  div_ctrl #(.W(RATIO_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ratio_i  (ratio_i),
    .term_i   (term),
    .load_o   (load),
    .en_o     (en),
    .preset_o (preset),
    .pulse_o  (pulse_o)
  );

  div_chain #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .preset_i (preset),
    .en_i     (en),
    .cnt_o    (cnt),
    .term_o   (term)
  );
endmodule

// File: rtl/rate_divider_chk.sv
module rate_divider_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] ratio_i,
  input logic         pulse_o,
  input logic [W-1:0] cnt_i,
  input logic         load_i,
  input logic         en_i
);
  logic [W-1:0] ratio_d;
  logic [W-1:0] per_q;
  logic [W:0]   gap_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_d <= '0;
      per_q   <= '0;
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      ratio_d <= ratio_i;
      if (pulse_o) begin
        gap_q   <= (W+1)'(1);
        per_q   <= ratio_d;
        armed_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + (W+1)'(1);
      end
    end
  end

  assert_low_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !pulse_o);

  assert_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && pulse_o |-> gap_q == {1'b0, per_q});

  assert_one_cycle_wide_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o && ratio_d != W'(1) |=> !pulse_o);

  assert_unit_ratio_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o && ratio_d == W'(1) |=> pulse_o);

  assert_step_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> cnt_i == ($past(cnt_i) - W'(1)));

  assert_reload_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_i == ($past(ratio_i) - W'(1)));
endmodule

bind rate_divider rate_divider_chk #(.W(RATIO_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ratio_i (ratio_i),
  .pulse_o (pulse_o),
  .cnt_i   (cnt),
  .load_i  (load),
  .en_i    (en)
);

// File: tb/sim_rate_divider.sv
`timescale 1ns/1ps
module sim_rate_divider;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ratio_i = 8'd5;
  logic       pulse_o;

  int n_checks = 0;
  int n_errors = 0;

  rate_divider u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_i),
    .pulse_o (pulse_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int guard = 0;
    do begin
      @(negedge clk_i);
      guard++;
    end while (!pulse_o && guard < 1000);
  endtask

  // cycles from the current pulse to the next one
  task automatic gap_len(output int len);
    len = 0;
    do begin
      @(negedge clk_i);
      len++;
    end while (!pulse_o && len < 1000);
  endtask

  task automatic t_reset_and_first(input int n);
    int first_hi;
    ratio_i = 8'(n);
    rst_ni  = 1'b0;
    repeat (3) @(negedge clk_i);
    check(pulse_o === 1'b0, "R1", int'(pulse_o), 0);
    rst_ni = 1'b1;
    first_hi = 0;
    for (int i = 1; i <= n + 1; i++) begin
      @(negedge clk_i);
      if (pulse_o === 1'b1 && first_hi == 0) first_hi = i;
    end
    // load at edge 1, pulse rises N edges later: visible at negedge N+1
    check(first_hi == n + 1, "R2", first_hi, n + 1);
  endtask

  task automatic t_period(input int n, input string req);
    int len;
    ratio_i = 8'(n);
    wait_pulse();
    for (int p = 0; p < 2; p++) begin
      gap_len(len);
      check(len == n, req, len, n);
    end
    if (n > 1) begin
      @(negedge clk_i);
      check(pulse_o === 1'b0, {req, " width"}, int'(pulse_o), 0);
    end
  endtask

  task automatic t_unit_ratio();
    int highs = 0;
    ratio_i = 8'd1;
    wait_pulse();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (pulse_o === 1'b1) highs++;
    end
    check(highs == 20, "R4", highs, 20);
  endtask

  task automatic t_midperiod_change();
    int len;
    t_reset_and_first(40);
    repeat (10) @(negedge clk_i);
    ratio_i = 8'd7;
    len = 10;
    do begin
      @(negedge clk_i);
      len++;
    end while (!pulse_o && len < 1000);
    check(len == 40, "R6 current period", len, 40);
    gap_len(len);
    check(len == 7, "R6 next period", len, 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    t_reset_and_first(5);
    t_period(5, "R3 n5");
    t_period(2, "R3 n2");
    t_unit_ratio();
    t_period(15, "R7 n15");
    t_period(16, "R7 n16");
    t_period(17, "R7 n17");
    t_period(255, "R5 n255");
    t_reset_and_first(1);
    t_unit_ratio();
    t_midperiod_change();
    // R8 via ports: after reload with 3, period follows the new value
    t_period(3, "R8 n3");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule